// File: doc/BRIEF.md
# Clock Synthesizer Control Register File

This block is the control store for a video clock generator. Software reaches it through a two-address port. Address 0 holds an index, and address 1 reads or writes the byte that the index selects. A bank of extended registers covers indices 0x08 to 0x18. Index 0x08 is a key register that can always be reached. The rest of the bank opens only while the key register holds 0x06.

The bank holds a staged copy of the PLL coefficients: multiplier M, divider N and post-divider exponent R. A separate active copy drives the clock generator. The active copy changes only when software writes index 0x15 with bit 5 set. That write copies the staged values across in one cycle, so the generator never sees a half-written set of coefficients.

A separate miscellaneous output byte selects the clock source in its bits 3:2. The clock doubler enable comes from two bits spread over two extended registers.

Top module: `clksyn_regfile`

## Requirements
- R1: A write with `bus_addr`=0 loads the index, and a read at address 0 returns it. With `bus_addr`=1, a write stores `bus_wdata` in the register the index selects, and `bus_rdata` returns that register combinationally.
- R2: While locked, writes to indices 0x09–0x18 are ignored, reads of them return 0x00, and a write of 0x15 with bit 5 set does not load the PLL.
- R3: Index 0x08 is always readable and writable and returns the last value written. Writing 0x06 to it unlocks the bank, and any other value locks it again. Registers keep their contents across a lock and a later unlock.
- R4: Index 0x12 stores R in bits 6:5 and N in bits 4:0. Index 0x13 stores M in bits 6:0. Bit 7 of both reads back as 0.
- R5: A data write to index 0x15 with bit 5 set copies the staged R, N and M into `pll_r`, `pll_n` and `pll_m`, which are visible after that clock edge.
- R6: The active coefficients do not change on any other write. This includes writes to 0x12 and 0x13, and writes to 0x15 with bit 5 clear.
- R7: `misc_wdata` is stored on `misc_wr` and read back on `misc_rdata`. `clk_src` equals its bits 3:2, where 00 is fixed clock 0, 01 is fixed clock 1 and 11 is the PLL. `pll_sel` is high only for 11.
- R8: `dbl_en` is the AND of bit 4 of index 0x15 and bit 7 of index 0x18.
- R9: After reset, every register is zero, the bank is locked, `clk_src` is 00 and the active coefficients are zero.
- R10: Indices outside 0x08–0x18 read 0x00 on the data address, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the index/data port |
| bus_addr | input | 1 | 0 = index, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| misc_wr | input | 1 | Write strobe for the miscellaneous output byte |
| misc_wdata | input | 8 | Miscellaneous output byte to store |
| misc_rdata | output | 8 | Stored miscellaneous output byte |
| pll_m | output | 7 | Active multiplier M |
| pll_n | output | 5 | Active divider N |
| pll_r | output | 2 | Active post-divider exponent R |
| clk_src | output | 2 | Selected clock source |
| pll_sel | output | 1 | High when the PLL is the selected source |
| dbl_en | output | 1 | Clock doubler enable |

## Verification
The load path is tested with several writes to index 0x15:
- bit 5 clear;
- bit 5 set;
- bit 4 only;
- bit 5 set while the bank is locked.

Only the second may move the active coefficients, so a design that loads on the wrong bit, loads as a level, or ignores the lock is caught. Staged writes of all ones and of mixed patterns to 0x12 and 0x13 show that the fields are masked separately from the active copy. Writing a wrong key after an unlock, then unlocking again, shows that locking hides the contents without clearing them. Writes to unmapped indices show that nothing outside the bank is decoded.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  localparam int DW       = 8;
  localparam int IW       = 8;
  localparam int M_W      = 7;
  localparam int N_W      = 5;
  localparam int R_W      = 2;
  localparam int KEY_IDX  = 8'h08;
  localparam int KEY_VAL  = 8'h06;
  localparam int EXT_HI   = 8'h18;
  localparam int NR_IDX   = 8'h12;
  localparam int M_IDX    = 8'h13;
  localparam int CTL_IDX  = 8'h15;
  localparam int DBL2_IDX = 8'h18;
  localparam int LOAD_BIT = 5;
  localparam int DBL1_BIT = 4;
  localparam int DBL2_BIT = 7;
  localparam int R_LSB    = N_W;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } pll_coef_t;

  function automatic logic [DW-1:0] field_mask(input int idx);
    if (idx == NR_IDX) return DW'((1 << (R_W + N_W)) - 1);
    if (idx == M_IDX)  return DW'((1 << M_W) - 1);
    return {DW{1'b1}};
  endfunction
endpackage

// File: rtl/clksyn_index_lock.sv
module clksyn_index_lock
  import clksyn_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic          key_we,
  input  logic [DW-1:0] wdata,
  output logic [IW-1:0] idx,
  output logic [DW-1:0] key_q,
  output logic          unlocked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      key_q <= '0;
    end else begin
      if (idx_we) idx <= wdata[IW-1:0];
      if (key_we) key_q <= wdata;
    end
  end

  assign unlocked = (key_q == DW'(KEY_VAL));

  // R3: the lock state may only change on a key write
  p_lock_by_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !key_we |=> $stable(unlocked));
endmodule

// File: rtl/clksyn_ext_bank.sv
module clksyn_ext_bank
  import clksyn_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          unlocked,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output pll_coef_t     staged,
  output logic          dbl_a,
  output logic          dbl_b
);
  localparam int LO = KEY_IDX + 1;
  localparam int HI = EXT_HI;

  logic [DW-1:0] regs [LO:HI];

  for (genvar g = LO; g <= HI; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = field_mask(g);
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= '0;
      else if (we && unlocked && idx == IW'(g)) regs[g] <= wdata & MASK;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = LO; i <= HI; i++)
      if (unlocked && idx == IW'(i)) rdata = regs[i];
  end

  assign staged.r = regs[NR_IDX][R_LSB +: R_W];
  assign staged.n = regs[NR_IDX][N_W-1:0];
  assign staged.m = regs[M_IDX][M_W-1:0];
  assign dbl_a    = regs[CTL_IDX][DBL1_BIT];
  assign dbl_b    = regs[DBL2_IDX][DBL2_BIT];

  // R2: a locked bank reads as zero
  p_locked_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> rdata == '0);
endmodule

// File: rtl/clksyn_pll_active.sv
module clksyn_pll_active
  import clksyn_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  pll_coef_t staged,
  output pll_coef_t active
);
  always_ff @(posedge clk) begin
    if (!rst_n) active <= '0;
    else if (load) active <= staged;
  end

  // R5: a load pulse copies the staged set
  p_load_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active == $past(staged));
  // R6: without a load the active set holds
  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active));
endmodule

// File: rtl/clksyn_regfile.sv
module clksyn_regfile
  import clksyn_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          misc_wr,
  input  logic [DW-1:0] misc_wdata,
  output logic [DW-1:0] misc_rdata,
  output logic [M_W-1:0] pll_m,
  output logic [N_W-1:0] pll_n,
  output logic [R_W-1:0] pll_r,
  output logic [1:0]    clk_src,
  output logic          pll_sel,
  output logic          dbl_en
);
  logic [IW-1:0] idx;
  logic [DW-1:0] key_q, bank_rd, misc_q;
  logic          unlocked, data_we, key_we, load, dbl_a, dbl_b;
  pll_coef_t     staged, active;

  assign data_we = bus_wr && bus_addr;
  assign key_we  = data_we && idx == IW'(KEY_IDX);
  assign load    = data_we && unlocked && idx == IW'(CTL_IDX) && bus_wdata[LOAD_BIT];

  clksyn_index_lock u_lock (
    .clk(clk), .rst_n(rst_n), .idx_we(bus_wr && !bus_addr), .key_we(key_we),
    .wdata(bus_wdata), .idx(idx), .key_q(key_q), .unlocked(unlocked));

  clksyn_ext_bank u_bank (
    .clk(clk), .rst_n(rst_n), .we(data_we), .unlocked(unlocked), .idx(idx),
    .wdata(bus_wdata), .rdata(bank_rd), .staged(staged), .dbl_a(dbl_a), .dbl_b(dbl_b));

  clksyn_pll_active u_act (
    .clk(clk), .rst_n(rst_n), .load(load), .staged(staged), .active(active));

  always_ff @(posedge clk) begin
    if (!rst_n) misc_q <= '0;
    else if (misc_wr) misc_q <= misc_wdata;
  end

  always_comb begin
    if (!bus_addr)                 bus_rdata = DW'(idx);
    else if (idx == IW'(KEY_IDX))  bus_rdata = key_q;
    else                           bus_rdata = bank_rd;
  end

  assign misc_rdata = misc_q;
  assign clk_src    = misc_q[3:2];
  assign pll_sel    = (misc_q[3:2] == 2'b11);
  assign dbl_en     = dbl_a & dbl_b;
  assign pll_m      = active.m;
  assign pll_n      = active.n;
  assign pll_r      = active.r;

  // R7: the clock source moves only after a misc write
  p_src_by_misc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_src) |-> $past(misc_wr));
  // R8: the doubler turns on only through an unlocked data write
  p_dbl_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbl_en) |-> $past(data_we && unlocked));
  // R2: locked extended data reads return zero
  p_locked_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr && !unlocked && idx > IW'(KEY_IDX) && idx <= IW'(EXT_HI)) |-> bus_rdata == '0);
endmodule

// File: tb/clksyn_regfile_bench.sv
module clksyn_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_addr = 1'b0, misc_wr = 1'b0;
  logic [7:0] bus_wdata = '0, misc_wdata = '0;
  logic [7:0] bus_rdata, misc_rdata;
  logic [6:0] pll_m;
  logic [4:0] pll_n;
  logic [1:0] pll_r, clk_src;
  logic       pll_sel, dbl_en;

  int total = 0, bad = 0, cycles = 0;
  bit done = 1'b0;

  typedef struct { int kind; logic [15:0] exp; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  clksyn_regfile u_clksyn_regfile (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .misc_wr(misc_wr),
    .misc_wdata(misc_wdata), .misc_rdata(misc_rdata), .pll_m(pll_m),
    .pll_n(pll_n), .pll_r(pll_r), .clk_src(clk_src), .pll_sel(pll_sel),
    .dbl_en(dbl_en));

  function automatic logic [15:0] actual(int kind);
    case (kind)
      0: return {8'h00, bus_rdata};
      1: return {2'b00, pll_r, pll_n, pll_m};
      2: return {14'd0, clk_src};
      3: return {15'd0, pll_sel};
      4: return {15'd0, dbl_en};
      default: return {8'h00, misc_rdata};
    endcase
  endfunction

  // monitor: pops expected items and compares after the edge settles
  initial begin
    forever begin
      @(posedge clk); #5;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] a;
        it = q.pop_front();
        a = actual(it.kind);
        total++;
        if (a !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, a, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic set_idx(input logic [7:0] i); wr(1'b0, i); endtask
  task automatic wreg(input logic [7:0] i, input logic [7:0] d);
    set_idx(i); wr(1'b1, d);
  endtask

  task automatic mwr(input logic [7:0] d);
    @(negedge clk); misc_wr = 1'b1; misc_wdata = d;
    @(negedge clk); misc_wr = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic rreg(input logic [7:0] i, input logic [7:0] e, input string tag);
    set_idx(i);
    bus_addr = 1'b1;
    expect_item(0, {8'h00, e}, tag);
  endtask

  localparam logic [15:0] ACT1 = {2'b00, 2'b11, 5'h0A, 7'h45};

  // driver
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_addr = 1'b0;
    expect_item(0, 16'h0000, "R9 index after reset");
    expect_item(1, 16'h0000, "R9 active after reset");
    expect_item(2, 16'h0000, "R9 clk_src after reset");
    expect_item(4, 16'h0000, "R9 dbl_en after reset");
    rreg(8'h08, 8'h00, "R9 key after reset");

    wreg(8'h12, 8'h55);
    rreg(8'h12, 8'h00, "R2 locked write/read");

    wreg(8'h08, 8'h06);
    rreg(8'h08, 8'h06, "R3 key readback");
    bus_addr = 1'b0;
    expect_item(0, 16'h0008, "R1 index readback");

    wreg(8'h12, 8'hFF);
    rreg(8'h12, 8'h7F, "R4 nr mask");
    wreg(8'h12, 8'h6A);
    rreg(8'h12, 8'h6A, "R1 R4 nr value");
    wreg(8'h13, 8'hC5);
    rreg(8'h13, 8'h45, "R4 m mask");
    expect_item(1, 16'h0000, "R6 staged writes only");

    wreg(8'h15, 8'h00);
    expect_item(1, 16'h0000, "R6 ctl bit5 clear");
    wreg(8'h15, 8'h20);
    expect_item(1, ACT1, "R5 immediate load");
    wreg(8'h12, 8'h01);
    expect_item(1, ACT1, "R6 staged change after load");
    wreg(8'h15, 8'h10);
    expect_item(1, ACT1, "R6 ctl bit4 only");
    rreg(8'h15, 8'h10, "R1 ctl readback");

    expect_item(4, 16'h0000, "R8 half enable");
    wreg(8'h18, 8'h80);
    expect_item(4, 16'h0001, "R8 both bits");
    wreg(8'h15, 8'h00);
    expect_item(4, 16'h0000, "R8 ctl bit cleared");

    wreg(8'h20, 8'h77);
    rreg(8'h20, 8'h00, "R10 unmapped high");
    wreg(8'h07, 8'h33);
    rreg(8'h07, 8'h00, "R10 unmapped low");

    wreg(8'h08, 8'h07);
    rreg(8'h08, 8'h07, "R3 wrong key readback");
    rreg(8'h12, 8'h00, "R2 relocked read");
    wreg(8'h15, 8'h30);
    expect_item(1, ACT1, "R2 locked load ignored");
    expect_item(4, 16'h0000, "R2 locked ctl write ignored");
    wreg(8'h08, 8'h06);
    rreg(8'h12, 8'h01, "R3 contents kept");
    rreg(8'h15, 8'h00, "R2 ctl unchanged by locked write");

    mwr(8'h0C);
    expect_item(2, 16'h0003, "R7 pll source");
    expect_item(3, 16'h0001, "R7 pll_sel");
    expect_item(5, 16'h000C, "R7 misc readback");
    mwr(8'h04);
    expect_item(2, 16'h0001, "R7 fixed clock 1");
    expect_item(3, 16'h0000, "R7 pll_sel low");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (done || cycles > 20000) begin
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule